// File: doc/BRIEF.md
# Flagged FIFO with Rewind and Chain Tokens

A single-clock first-in first-out buffer, 1024 words of 9 bits by default. Write and read strobes are sampled as enables on the rising clock edge. Three active-low flags report the occupancy: empty, full and more-than-half-full. A master reset clears both pointers and the occupancy count.

A mode input selects the role of the buffer.

- **Standalone role.** A shared control input acts as an active-low rewind command. It returns the read pointer to location zero, so that everything written since reset can be read again.
- **Chained role.** Several buffers are joined in a ring to build a deeper queue. The shared control input, held low during reset, marks the device that starts out owning both the write and the read token. The half-full pin then carries a one-cycle link pulse, which hands a token on to the next device in the ring.

Top module: `retx_fifo`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after its release, both pointers and the occupancy are zero, `empty_n`=0, `full_n`=1, `half_or_link_n`=1 and `rd_data`=0. Strobes presented during reset change nothing.
- R2: Words are read back in the order written. `rd_data` takes the word at the read pointer on the clock edge that accepts a read, and holds its value otherwise.
- R3: `full_n` is 0 exactly when 1024 words are held. A write presented while `full_n` is 0 is dropped and never appears at the output.
- R4: A read presented while `empty_n` is 0 is dropped: `rd_data` keeps its last value and `empty_n` stays 0.
- R5: In the standalone role, `half_or_link_n` is 0 when more than 512 words are held and 1 when 512 or fewer are held.
- R6: A read and a write accepted in the same cycle leave the occupancy and the flags unchanged.
- R7: In the standalone role, `load_rewind_n`=0 sampled with `rst_n`=1 rewinds the read pointer to 0 and leaves the write pointer alone. The occupancy becomes the number of words written since reset (valid while fewer than 1024 have been written). Read and write strobes in that cycle are ignored, and the flags are valid on the next cycle.
- R8: In the chained role, a device with `load_rewind_n`=0 during reset starts with both tokens and the others start with none. A write without the write token, or a read without the read token, is ignored.
- R9: In the chained role, an accepted write to the last location (1023), or an accepted read from it, releases the matching token. It also drives `half_or_link_n` low for exactly the next cycle.
- R10: In the chained role, each cycle with `chain_in_n`=0 grants one token. Grants alternate between the write token and the read token, starting with write after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Master reset, active low, synchronous |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 9 | Word to write |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 9 | Registered read word |
| chain_mode | input | 1 | 0 = standalone, 1 = chained |
| load_rewind_n | input | 1 | Rewind command (standalone) or first-device mark sampled in reset (chained) |
| chain_in_n | input | 1 | Token pulse from the previous device |
| empty_n | output | 1 | Low when no word is held |
| full_n | output | 1 | Low when 1024 words are held |
| half_or_link_n | output | 1 | Half-full flag (standalone) or token pulse out (chained) |

## Verification
A wrong pointer shows up at `rd_data` on the first read that follows it, as a word out of order. A wrong occupancy count shows up in the flags: either at once in the half or empty flag, or when the buffer is later filled or drained to a boundary and a flag fails to change on the expected write or read. A lost or duplicated token shows up as a write or read that is accepted when it should be ignored, which is visible through `empty_n`, `full_n` or `rd_data` on the next cycle. A missing or stretched link pulse is visible at `half_or_link_n` one cycle after the last-location access.

// File: rtl/retx_fifo_pkg.sv
package retx_fifo_pkg;

    typedef struct packed {
        logic empty_n;
        logic full_n;
        logic half_n;
    } flags_t;

endpackage

// File: rtl/retx_fifo_store.sv
module retx_fifo_store #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 9,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] rdata_d, rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata_d = rdata_q;
        if (re) begin
            rdata_d = mem_q[raddr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/retx_fifo_ctrl.sv
module retx_fifo_ctrl
    import retx_fifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic          retx,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          wr_last,
    output logic          rd_last,
    output flags_t        flags
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        wr_ok = rst_n && wr_req && !retx && (st_q.cnt != FULL);
        rd_ok = rst_n && rd_req && !retx && (st_q.cnt != '0);
        if (retx) begin
            st_d.rp  = '0;
            st_d.cnt = CW'(st_q.wp);
        end else begin
            if (wr_ok) begin
                st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + AW'(1);
            end
            if (rd_ok) begin
                st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + AW'(1);
            end
            st_d.cnt = st_q.cnt + CW'(wr_ok) - CW'(rd_ok);
        end
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign waddr         = st_q.wp;
    assign raddr         = st_q.rp;
    assign wr_last       = (st_q.wp == LAST);
    assign rd_last       = (st_q.rp == LAST);
    assign flags.empty_n = rst_n && (st_q.cnt != '0);
    assign flags.full_n  = !rst_n || (st_q.cnt != FULL);
    assign flags.half_n  = !rst_n || (st_q.cnt <= HALF);

    // R1: a released reset leaves pointers and count cleared
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st_q.cnt == '0 && st_q.wp == '0 && st_q.rp == '0));

    // R3: a full buffer with no read stays full and its write pointer holds
    p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == FULL && !rd_req && !retx) |=> (st_q.cnt == FULL && $stable(st_q.wp)));

    // R4: an empty buffer with no write stays empty and its read pointer holds
    p_empty_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && !wr_req && !retx) |=> (st_q.cnt == '0 && $stable(st_q.rp)));

    // R6: outside rewind the count moves by at most one per cycle
    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !retx |=> (st_q.cnt == $past(st_q.cnt) || st_q.cnt == $past(st_q.cnt) + CW'(1)
                   || st_q.cnt == $past(st_q.cnt) - CW'(1)));

    // R3: occupancy never exceeds the capacity
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL);

    // R7: rewind zeroes the read pointer and keeps the write pointer
    p_rewind_r7: assert property (@(posedge clk) disable iff (!rst_n)
        retx |=> (st_q.rp == '0 && $stable(st_q.wp)));

endmodule

// File: rtl/retx_fifo_chain.sv
module retx_fifo_chain (
    input  logic clk,
    input  logic rst_n,
    input  logic chain_mode,
    input  logic first_n,
    input  logic link_in_n,
    input  logic wr_hand,
    input  logic rd_hand,
    output logic wr_tok,
    output logic rd_tok,
    output logic link_out_n
);

    typedef struct packed {
        logic wt;
        logic rt;
        logic next_wr;
        logic link_n;
    } tok_t;

    tok_t tk_d, tk_q;

    always_comb begin
        tk_d        = tk_q;
        tk_d.link_n = 1'b1;
        if (wr_hand) begin
            tk_d.wt     = 1'b0;
            tk_d.link_n = 1'b0;
        end
        if (rd_hand) begin
            tk_d.rt     = 1'b0;
            tk_d.link_n = 1'b0;
        end
        if (!link_in_n) begin
            if (tk_q.next_wr) begin
                tk_d.wt = 1'b1;
            end else begin
                tk_d.rt = 1'b1;
            end
            tk_d.next_wr = !tk_q.next_wr;
        end
        if (!chain_mode) begin
            tk_d.link_n = 1'b1;
        end
        if (!rst_n) begin
            tk_d.wt      = chain_mode && !first_n;
            tk_d.rt      = chain_mode && !first_n;
            tk_d.next_wr = 1'b1;
            tk_d.link_n  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        tk_q <= tk_d;
    end

    assign wr_tok     = !chain_mode || tk_q.wt;
    assign rd_tok     = !chain_mode || tk_q.rt;
    assign link_out_n = tk_q.link_n;

    // R9: a last-location write pulses the link and drops the write token
    p_wr_handoff_r9: assert property (@(posedge clk) disable iff (!rst_n || !chain_mode)
        (wr_hand && link_in_n) |=> (!link_out_n && !tk_q.wt));

    // R9: a last-location read pulses the link and drops the read token
    p_rd_handoff_r9: assert property (@(posedge clk) disable iff (!rst_n || !chain_mode)
        (rd_hand && link_in_n) |=> (!link_out_n && !tk_q.rt));

    // R10: one grant per low input cycle, alternating write then read
    p_grant_alt_r10: assert property (@(posedge clk) disable iff (!rst_n || !chain_mode)
        !link_in_n |=> (tk_q.next_wr != $past(tk_q.next_wr)));

endmodule

// File: rtl/retx_fifo.sv
module retx_fifo
    import retx_fifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 9,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    input  logic             chain_mode,
    input  logic             load_rewind_n,
    input  logic             chain_in_n,
    output logic             empty_n,
    output logic             full_n,
    output logic             half_or_link_n
);

    logic          wr_tok, rd_tok, wr_ok, rd_ok, wr_last, rd_last;
    logic          rewind, link_n;
    logic [AW-1:0] waddr, raddr;
    flags_t        flags;

    assign rewind = rst_n && !chain_mode && !load_rewind_n;

    retx_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (wr_en && wr_tok),
        .rd_req  (rd_en && rd_tok),
        .retx    (rewind),
        .wr_ok   (wr_ok),
        .rd_ok   (rd_ok),
        .waddr   (waddr),
        .raddr   (raddr),
        .wr_last (wr_last),
        .rd_last (rd_last),
        .flags   (flags)
    );

    retx_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ok),
        .waddr (waddr),
        .wdata (wr_data),
        .re    (rd_ok),
        .raddr (raddr),
        .rdata (rd_data)
    );

    retx_fifo_chain u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .chain_mode (chain_mode),
        .first_n    (load_rewind_n),
        .link_in_n  (chain_in_n),
        .wr_hand    (chain_mode && wr_ok && wr_last),
        .rd_hand    (chain_mode && rd_ok && rd_last),
        .wr_tok     (wr_tok),
        .rd_tok     (rd_tok),
        .link_out_n (link_n)
    );

    assign empty_n        = flags.empty_n;
    assign full_n         = flags.full_n;
    assign half_or_link_n = chain_mode ? link_n : flags.half_n;

    // R1: flags sit at their reset levels while reset is held
    p_reset_flags_r1: assert property (@(posedge clk) disable iff (rst_n)
        1'b1 |-> (!empty_n && full_n && half_or_link_n));

    // R8: without a write token the buffer cannot fill from empty
    p_no_token_write_r8: assert property (@(posedge clk) disable iff (!rst_n || !chain_mode)
        (!wr_tok && !empty_n) |=> !empty_n);

endmodule

// File: tb/tb_retx_fifo.sv
`timescale 1ns/1ps
module tb_retx_fifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic [8:0] rd_data;
    logic       chain_mode = 1'b0, load_rewind_n = 1'b1, chain_in_n = 1'b1;
    logic       empty_n, full_n, half_or_link_n;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    retx_fifo dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .chain_mode(chain_mode), .load_rewind_n(load_rewind_n),
        .chain_in_n(chain_in_n), .empty_n(empty_n), .full_n(full_n),
        .half_or_link_n(half_or_link_n)
    );

    // vector: {wr, rd, din, expected dout, expected {empty_n, full_n, half}}
    localparam logic [22:0] VEC [0:8] = '{
        {1'b1, 1'b0, 9'h1A5, 9'h000, 3'b111},
        {1'b1, 1'b0, 9'h05A, 9'h000, 3'b111},
        {1'b1, 1'b0, 9'h100, 9'h000, 3'b111},
        {1'b0, 1'b1, 9'h000, 9'h1A5, 3'b111},
        {1'b1, 1'b1, 9'h0FF, 9'h05A, 3'b111},
        {1'b0, 1'b1, 9'h000, 9'h100, 3'b111},
        {1'b0, 1'b1, 9'h000, 9'h0FF, 3'b011},
        {1'b0, 1'b1, 9'h000, 9'h0FF, 3'b011},
        {1'b1, 1'b0, 9'h033, 9'h0FF, 3'b111}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic r, input logic [8:0] d);
        wr_en = w; rd_en = r; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic do_reset(input logic mode, input logic first_n);
        rst_n = 1'b0; chain_mode = mode; load_rewind_n = first_n;
        wr_en = 1'b1; rd_en = 1'b1; wr_data = 9'h155;
        repeat (3) @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; load_rewind_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic link_pulse();
        chain_in_n = 1'b0;
        @(negedge clk);
        chain_in_n = 1'b1;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: state while reset is held, with strobes active
        rst_n = 1'b0; wr_en = 1'b1; rd_en = 1'b1; wr_data = 9'h1C3;
        repeat (3) @(negedge clk);
        chk("R1 empty_n in reset", empty_n, 0);
        chk("R1 full_n in reset", full_n, 1);
        chk("R1 half in reset", half_or_link_n, 1);
        chk("R1 rd_data in reset", rd_data, 0);
        do_reset(1'b0, 1'b1);
        chk("R1 empty after release", empty_n, 0);
        cyc(1'b0, 1'b1, 9'h0);
        chk("R1 read after reset ignored", rd_data, 0);

        // R2 R4 R6: table walk
        for (int i = 0; i < 9; i++) begin
            cyc(VEC[i][22], VEC[i][21], VEC[i][20:12]);
            chk($sformatf("R2/R4/R6 vec%0d dout", i), rd_data, VEC[i][11:3]);
            chk($sformatf("R2/R4/R6 vec%0d flags", i), {empty_n, full_n, half_or_link_n}, VEC[i][2:0]);
        end

        // R3 R5: fill to the boundaries, overflow, drain
        do_reset(1'b0, 1'b1);
        for (int i = 0; i < 1024; i++) begin
            cyc(1'b1, 1'b0, i[8:0]);
            if (i == 511) chk("R5 half at 512", half_or_link_n, 1);
            if (i == 512) chk("R5 half at 513", half_or_link_n, 0);
            if (i == 1022) chk("R3 full_n at 1023", full_n, 1);
        end
        chk("R3 full_n at 1024", full_n, 0);
        cyc(1'b1, 1'b0, 9'h1FF);
        chk("R3 full after dropped write", full_n, 0);
        for (int i = 0; i < 1024; i++) begin
            cyc(1'b0, 1'b1, 9'h0);
            chk("R2/R3 drain order", rd_data, {23'h0, i[8:0]});
            if (i == 510) chk("R5 half at 513 draining", half_or_link_n, 0);
            if (i == 511) chk("R5 half at 512 draining", half_or_link_n, 1);
        end
        chk("R3 empty after drain", empty_n, 0);
        cyc(1'b0, 1'b1, 9'h0);
        chk("R4 dropped read keeps data", rd_data, 9'h1FF);

        // R7: rewind
        do_reset(1'b0, 1'b1);
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 9'h010 + 9'(i));
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 9'h0);
        chk("R7 before rewind", rd_data, 9'h012);
        load_rewind_n = 1'b0;
        cyc(1'b1, 1'b1, 9'h077);
        load_rewind_n = 1'b1;
        chk("R7 read ignored in rewind", rd_data, 9'h012);
        chk("R7 empty_n after rewind", empty_n, 1);
        for (int i = 0; i < 5; i++) begin
            cyc(1'b0, 1'b1, 9'h0);
            chk("R7 replay", rd_data, 9'h010 + 9'(i));
        end
        chk("R7 write ignored in rewind", empty_n, 0);

        // R8 R9 R10: first device of a chain
        do_reset(1'b1, 1'b0);
        for (int i = 0; i < 1024; i++) begin
            cyc(1'b1, 1'b0, i[8:0]);
            if (i == 1022) chk("R9 no link before last write", half_or_link_n, 1);
        end
        chk("R9 link pulse after last write", half_or_link_n, 0);
        cyc(1'b0, 1'b1, 9'h0);
        chk("R9 link pulse one cycle", half_or_link_n, 1);
        chk("R2 chained first read", rd_data, 9'h000);
        cyc(1'b1, 1'b0, 9'h0C3);
        chk("R8 write without token ignored", full_n, 1);
        link_pulse();
        cyc(1'b1, 1'b0, 9'h0C3);
        chk("R10 write token granted", full_n, 0);
        for (int i = 1; i < 1024; i++) begin
            cyc(1'b0, 1'b1, 9'h0);
            if (i == 1022) chk("R9 no link before last read", half_or_link_n, 1);
        end
        chk("R9 link pulse after last read", half_or_link_n, 0);
        chk("R2 chained last read", rd_data, 9'h1FF);
        cyc(1'b0, 1'b1, 9'h0);
        chk("R8 read without token ignored", rd_data, 9'h1FF);
        chk("R8 held word remains", empty_n, 1);
        link_pulse();
        cyc(1'b0, 1'b1, 9'h0);
        chk("R10 read token granted", rd_data, 9'h0C3);

        // R8 R10: other device of a chain
        do_reset(1'b1, 1'b1);
        cyc(1'b1, 1'b0, 9'h02E);
        chk("R8 non-first write ignored", empty_n, 0);
        link_pulse();
        cyc(1'b1, 1'b0, 9'h02E);
        chk("R10 non-first write after grant", empty_n, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule